// File: doc/BRIEF.md
# Fuzzy PI DC-Link Voltage Regulator

This block closes a discrete-time voltage loop around a split DC link. It is built from four series capacitors. On each accepted sample it averages the four capacitor voltages and subtracts the setpoint to form an error. It takes the difference from the error of the previous accepted sample. Each of the two quantities is scaled by its own programmable gain and sorted into one of seven crisp linguistic sets. The pair of sets selects an adaptive output gain from a 7x7 rule table.

The block does not produce the current reference directly. It produces an increment equal to the negated product of the table gain and the scaled error, so a low link voltage raises the reference. A saturating accumulator integrates the increments, which gives proportional-integral behaviour with anti-windup clamping at programmable limits. The accumulated value is the current-reference command for an inner current loop.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream. Only one sample is in flight at a time. The input is not ready while a sample is being processed or while a result waits to be taken. A result is held, unchanged, until the consumer raises ready. Gains and limits are plain control inputs, captured when a sample is accepted.

Top module: `dclink_fuzzy_reg`

## Requirements
- R1: The regulated voltage is the mean of the four unsigned capacitor voltages on `cell_v` (cell i in bits 12i+11..12i), truncated: floor(sum/4).
- R2: The error is mean minus `v_ref`. The change of error is this error minus the error of the previously accepted sample.
- R3: The scaled error is floor(error * `gain_e` / 16) and the scaled change is floor(change * `gain_de` / 16). Both gains are unsigned with four fraction bits and are captured at acceptance.
- R4: Each scaled input x maps to set index 0..6 (NB=0, NM=1, NS=2, ZE=3, PS=4, PM=5, PB=6). Let m=|x| and lvl = 0 if m<16, 1 if m<64, 2 if m<256, else 3. The index is 3-lvl for negative x and 3+lvl otherwise.
- R5: The gain level L (PVS=0, PS=1, PM=2, PB=3, PVB=4) is read from a 7x7 table indexed by [change set][error set]. The rows for change set 0 to 6 list L for error set 0 to 6: 4432100, 4321000, 3210001, 2100012, 1000123, 0001234, 4412344. The multiplier is L+1.
- R6: The increment is -(L+1) * scaled error. It is added to the accumulator, and the new accumulator value is presented on `o_iref` (signed, 24 bits).
- R7: The accumulator sum is clamped to [`lim_lo`, `lim_hi`] (signed, captured at acceptance, lim_lo <= lim_hi).
- R8: `s_ready` is high only when no sample is being processed and no result is pending. A sample is accepted on a rising edge where `s_valid` and `s_ready` are both high, and `s_ready` is low in the following cycle.
- R9: `o_valid` rises on the third rising edge after the accepting edge.
- R10: While `o_valid` is high and `o_ready` is low, `o_valid` stays high and `o_iref` holds its value. The result is consumed on an edge where both are high.
- R11: Reset clears the accumulator, the previous error and `o_valid`. `s_ready` is high after reset, and the first sample after reset therefore sees its change equal to its error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready |
| cell_v | input | 48 | Four unsigned capacitor voltages, 12 bits each |
| v_ref | input | 12 | Unsigned voltage setpoint |
| gain_e | input | 8 | Error gain, unsigned, 4 fraction bits |
| gain_de | input | 8 | Change-of-error gain, unsigned, 4 fraction bits |
| lim_lo | input | 24 | Signed lower accumulator limit |
| lim_hi | input | 24 | Signed upper accumulator limit |
| o_valid | output | 1 | Result valid |
| o_ready | input | 1 | Result ready |
| o_iref | output | 24 | Signed current-reference command |

## Verification
The accumulator and the previous-error register are the only long-lived state. A corrupted accumulator shows up on `o_iref` in the very next result. A wrong previous error changes the change-of-error set, and so the table gain, and this appears as a wrong increment one sample later. A wrong set boundary or table entry appears only when the inputs land on that cell, so directed samples sit on every threshold edge while random samples sweep the table. A stage-sequencing fault shows immediately as a latency other than three edges or as `s_ready` overlapping a pending result.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  typedef enum logic [2:0] {
    FS_NB = 3'd0, FS_NM = 3'd1, FS_NS = 3'd2, FS_ZE = 3'd3,
    FS_PS = 3'd4, FS_PM = 3'd5, FS_PB = 3'd6
  } fset_t;

  typedef enum logic [2:0] {
    GL_VS = 3'd0, GL_S = 3'd1, GL_M = 3'd2, GL_B = 3'd3, GL_VB = 3'd4
  } glev_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCALE, ST_LOOK, ST_ACC, ST_OUT
  } st_t;

  // Each row is one change-of-error set; octal digit k (from the right)
  // is the gain level for error set k.
  function automatic glev_t rule_gain(input fset_t e_set, input fset_t de_set);
    logic [20:0] row;
    logic [2:0]  lvl;
    int unsigned pos;
    case (de_set)
      FS_NB:   row = 21'o0012344;
      FS_NM:   row = 21'o0001234;
      FS_NS:   row = 21'o1000123;
      FS_ZE:   row = 21'o2100012;
      FS_PS:   row = 21'o3210001;
      FS_PM:   row = 21'o4321000;
      FS_PB:   row = 21'o4432144;
      default: row = 21'o0000000;
    endcase
    pos = 3 * int'(e_set);
    lvl = row[pos +: 3];
    return glev_t'(lvl);
  endfunction

endpackage

// File: rtl/dcl_mean.sv
module dcl_mean #(
  parameter int N  = 4,
  parameter int VW = 12
) (
  input  logic [N*VW-1:0] v_i,
  output logic [VW-1:0]   avg_o
);
  localparam int SH   = $clog2(N);
  localparam int SUMW = VW + SH;

  logic [SUMW-1:0] part [N+1];

  assign part[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_add
    assign part[g+1] = part[g] + SUMW'(v_i[g*VW +: VW]);
  end

  assign avg_o = VW'(part[N] >> SH);
endmodule

// File: rtl/dcl_fuzz.sv
module dcl_fuzz import dcl_pkg::*; #(
  parameter int W  = 23,
  parameter int T1 = 16,
  parameter int T2 = 64,
  parameter int T3 = 256
) (
  input  logic signed [W-1:0] x_i,
  output fset_t               set_o
);
  localparam int MW = W + 1;

  logic signed [MW-1:0] xe;
  logic [MW-1:0]        mag;
  logic [2:0]           lvl;

  always_comb begin
    xe  = MW'(x_i);
    mag = x_i[W-1] ? MW'(-xe) : MW'(xe);
    if (mag < MW'(T1))      lvl = 3'd0;
    else if (mag < MW'(T2)) lvl = 3'd1;
    else if (mag < MW'(T3)) lvl = 3'd2;
    else                    lvl = 3'd3;
    set_o = x_i[W-1] ? fset_t'(3'd3 - lvl) : fset_t'(3'd3 + lvl);
  end
endmodule

// File: rtl/dcl_sat_acc.sv
module dcl_sat_acc #(
  parameter int IW = 27,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic signed [IW-1:0] inc_i,
  input  logic signed [AW-1:0] lo_i,
  input  logic signed [AW-1:0] hi_i,
  output logic signed [AW-1:0] acc_o
);
  localparam int NW = ((AW > IW) ? AW : IW) + 2;

  logic signed [NW-1:0] sum_w, lo_w, hi_w;
  logic signed [AW-1:0] nxt;

  always_comb begin
    sum_w = NW'(acc_o) + NW'(inc_i);
    lo_w  = NW'(lo_i);
    hi_w  = NW'(hi_i);
    if (sum_w > hi_w)      nxt = hi_i;
    else if (sum_w < lo_w) nxt = lo_i;
    else                   nxt = AW'(sum_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_o <= '0;
    else if (en_i) acc_o <= nxt;
  end
endmodule

// File: rtl/dclink_fuzzy_reg.sv
module dclink_fuzzy_reg import dcl_pkg::*; #(
  parameter int NCELL = 4,
  parameter int VW    = 12,
  parameter int GW    = 8,
  parameter int GSH   = 4,
  parameter int AW    = 24,
  parameter int T1    = 16,
  parameter int T2    = 64,
  parameter int T3    = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [NCELL*VW-1:0]   cell_v,
  input  logic [VW-1:0]         v_ref,
  input  logic [GW-1:0]         gain_e,
  input  logic [GW-1:0]         gain_de,
  input  logic signed [AW-1:0]  lim_lo,
  input  logic signed [AW-1:0]  lim_hi,
  output logic                  o_valid,
  input  logic                  o_ready,
  output logic signed [AW-1:0]  o_iref
);
  localparam int EW = VW + 2;
  localparam int SW = EW + GW + 1;
  localparam int IW = SW + 4;

  st_t state;

  logic [VW-1:0]          avg;
  logic signed [EW-1:0]   err_now, err_r, derr_r, prev_err;
  logic [GW-1:0]          ge_r, gde_r;
  logic signed [AW-1:0]   lo_r, hi_r;
  logic signed [SW-1:0]   prod_e, prod_de, se_r, sde_r;
  logic signed [SW-1:0]   fz_in  [2];
  fset_t                  fz_out [2];
  glev_t                  gl_r;
  logic [3:0]             gmul;
  logic signed [IW-1:0]   inc_w;
  logic                   o_valid_r;

  dcl_mean #(.N(NCELL), .VW(VW)) u_mean (.v_i(cell_v), .avg_o(avg));

  assign err_now = $signed(EW'(avg)) - $signed(EW'(v_ref));

  assign prod_e  = SW'(err_r)  * $signed({{(SW-GW){1'b0}}, ge_r});
  assign prod_de = SW'(derr_r) * $signed({{(SW-GW){1'b0}}, gde_r});

  assign fz_in[0] = se_r;
  assign fz_in[1] = sde_r;

  for (genvar g = 0; g < 2; g++) begin : g_fz
    dcl_fuzz #(.W(SW), .T1(T1), .T2(T2), .T3(T3)) u_fz (
      .x_i  (fz_in[g]),
      .set_o(fz_out[g])
    );
  end

  assign gmul  = {1'b0, gl_r} + 4'd1;
  assign inc_w = -(IW'(se_r) * $signed({{(IW-4){1'b0}}, gmul}));

  dcl_sat_acc #(.IW(IW), .AW(AW)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (state == ST_ACC),
    .inc_i(inc_w),
    .lo_i (lo_r),
    .hi_i (hi_r),
    .acc_o(o_iref)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      err_r     <= '0;
      derr_r    <= '0;
      prev_err  <= '0;
      ge_r      <= '0;
      gde_r     <= '0;
      lo_r      <= '0;
      hi_r      <= '0;
      se_r      <= '0;
      sde_r     <= '0;
      gl_r      <= GL_VS;
      o_valid_r <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (s_valid) begin
          err_r    <= err_now;
          derr_r   <= err_now - prev_err;
          prev_err <= err_now;
          ge_r     <= gain_e;
          gde_r    <= gain_de;
          lo_r     <= lim_lo;
          hi_r     <= lim_hi;
          state    <= ST_SCALE;
        end
        ST_SCALE: begin
          se_r  <= prod_e >>> GSH;
          sde_r <= prod_de >>> GSH;
          state <= ST_LOOK;
        end
        ST_LOOK: begin
          gl_r  <= rule_gain(fz_out[0], fz_out[1]);
          state <= ST_ACC;
        end
        ST_ACC: begin
          o_valid_r <= 1'b1;
          state     <= ST_OUT;
        end
        ST_OUT: if (o_ready) begin
          o_valid_r <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_ready = (state == ST_IDLE);
  assign o_valid = o_valid_r;
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk #(
  parameter int AW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 o_valid,
  input logic                 o_ready,
  input logic signed [AW-1:0] o_iref,
  input logic signed [AW-1:0] lo_r,
  input logic signed [AW-1:0] hi_r
);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_valid && s_ready, 4) |-> o_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_iref)));

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && (lo_r <= hi_r)) |-> ((o_iref >= lo_r) && (o_iref <= hi_r)));
endmodule

bind dclink_fuzzy_reg dcl_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .o_valid(o_valid),
  .o_ready(o_ready),
  .o_iref (o_iref),
  .lo_r   (lo_r),
  .hi_r   (hi_r)
);

// File: tb/sim_dclink_fuzzy_reg.sv
module sim_dclink_fuzzy_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [47:0] cell_v = '0;
  logic [11:0] v_ref = '0;
  logic [7:0]  gain_e = 8'd16;
  logic [7:0]  gain_de = 8'd16;
  logic [23:0] lim_lo = '0;
  logic [23:0] lim_hi = '0;
  logic        o_valid;
  logic        o_ready = 1'b0;
  logic [23:0] o_iref;

  int     nchk = 0;
  int     nerr = 0;
  bit     done = 0;
  longint m_prev = 0;
  longint m_acc = 0;
  int     ge = 16, gde = 16, lo = -100000, hi = 100000;

  always #(CLK_PERIOD/2) clk = ~clk;

  dclink_fuzzy_reg u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .cell_v(cell_v), .v_ref(v_ref), .gain_e(gain_e), .gain_de(gain_de),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .o_valid(o_valid), .o_ready(o_ready),
    .o_iref(o_iref)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int set_of(input longint x);
    longint m;
    int lvl;
    m = (x < 0) ? -x : x;
    lvl = (m < 16) ? 0 : (m < 64) ? 1 : (m < 256) ? 2 : 3;
    return (x < 0) ? 3 - lvl : 3 + lvl;
  endfunction

  function automatic int table_lvl(input int de_set, input int e_set);
    string rows [7];
    rows = '{"4432100", "4321000", "3210001", "2100012", "1000123", "0001234", "4412344"};
    return int'(rows[de_set][e_set]) - 48;
  endfunction

  function automatic longint model(input int v0, input int v1, input int v2, input int v3, input int vr);
    longint avg, e, d, se, sde, a;
    int lv;
    avg = longint'((v0 + v1 + v2 + v3) / 4);
    e = avg - vr;
    d = e - m_prev;
    m_prev = e;
    se  = (e * ge) >>> 4;
    sde = (d * gde) >>> 4;
    lv = table_lvl(set_of(sde), set_of(se));
    a = m_acc - (lv + 1) * se;
    if (a > hi) a = hi;
    if (a < lo) a = lo;
    m_acc = a;
    return a;
  endfunction

  task automatic apply_ctrl();
    gain_e  = 8'(ge);
    gain_de = 8'(gde);
    lim_lo  = 24'(lo);
    lim_hi  = 24'(hi);
  endtask

  task automatic run(input int v0, input int v1, input int v2, input int v3,
                     input int vr, input int hold, input string req);
    longint exp, held;
    int lat;
    bit stable_ok;
    @(negedge clk);
    apply_ctrl();
    exp = model(v0, v1, v2, v3, vr);
    cell_v = {12'(v3), 12'(v2), 12'(v1), 12'(v0)};
    v_ref = 12'(vr);
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    chk(!s_ready, "R8 busy after accept", longint'(s_ready), 0);
    lat = 0;
    while (!o_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, "R9 latency", lat, 3);
    held = longint'($signed(o_iref));
    stable_ok = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!o_valid || s_ready || longint'($signed(o_iref)) != held) stable_ok = 1'b0;
    end
    if (hold > 0) chk(stable_ok, "R10 hold under back-pressure", longint'($signed(o_iref)), held);
    chk(longint'($signed(o_iref)) == exp, req, longint'($signed(o_iref)), exp);
    o_ready = 1'b1;
    @(negedge clk);
    o_ready = 1'b0;
    chk(!o_valid && s_ready, "R10 consumed", longint'(o_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    apply_ctrl();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(o_iref == 24'd0, "R11 reset accumulator", longint'($signed(o_iref)), 0);
    chk(!o_valid, "R11 reset o_valid", longint'(o_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready, "R8 R11 ready after reset", longint'(s_ready), 1);

    // R2 R6: zero error leaves accumulator at zero
    run(2000, 2000, 2000, 2000, 2000, 0, "R2 R6 zero error");
    // R1: mean truncates (sum 4003 -> 1000)
    run(1000, 1001, 1001, 1001, 1000, 0, "R1 truncated mean");
    // R4: threshold edges on both signs
    run(2015, 2015, 2015, 2015, 2000, 0, "R4 edge 15");
    run(2016, 2016, 2016, 2016, 2000, 0, "R4 edge 16");
    run(2063, 2063, 2063, 2063, 2000, 0, "R4 edge 63");
    run(2064, 2064, 2064, 2064, 2000, 0, "R4 edge 64");
    run(2255, 2255, 2255, 2255, 2000, 0, "R4 edge 255");
    run(2256, 2256, 2256, 2256, 2000, 0, "R4 edge 256");
    run(1984, 1984, 1984, 1984, 2000, 0, "R4 edge -16");
    run(1983, 1983, 1983, 1983, 2000, 0, "R4 edge -17");
    run(1744, 1744, 1744, 1744, 2000, 0, "R4 R5 edge -256");
    // R3: half gain with floor on negative products
    ge = 8; gde = 24;
    run(1967, 1967, 1967, 1967, 2000, 0, "R3 scaled gains");
    run(2033, 2033, 2033, 2033, 2000, 0, "R3 scaled gains positive");
    ge = 0;
    run(3000, 3000, 3000, 3000, 100, 0, "R3 zero gain");
    ge = 16; gde = 16;
    // R7: clamp at upper and lower limits
    hi = 50;
    run(1000, 1000, 1000, 1000, 3000, 0, "R7 upper clamp");
    lo = -30; hi = 100000;
    run(3000, 3000, 3000, 3000, 1000, 0, "R7 lower clamp");
    lo = -100000;
    // R10: back-pressure
    run(2100, 2100, 2100, 2100, 2000, 6, "R6 R10 held result");

    // R11: reset mid-run clears accumulator and previous error
    @(negedge clk);
    rst_n = 1'b0;
    m_acc = 0; m_prev = 0;
    @(negedge clk);
    chk(o_iref == 24'd0, "R11 mid-run reset", longint'($signed(o_iref)), 0);
    rst_n = 1'b1;
    run(1700, 1700, 1700, 1700, 2000, 0, "R11 R2 first sample after reset");

    // Random sweep of gains, errors and back-pressure (R5 R6 R7)
    lo = -4000000; hi = 4000000;
    for (int n = 0; n < 120; n++) begin
      int base, sp;
      base = 800 + int'($urandom_range(2200));
      sp = int'($urandom_range(1200)) - 600;
      ge  = int'($urandom_range(63));
      gde = int'($urandom_range(63));
      if (n % 30 == 29) begin lo = -2000; hi = 2000; end
      else if (n % 30 == 0) begin lo = -4000000; hi = 4000000; end
      run(base + sp + int'($urandom_range(6)), base + sp, base + sp - int'($urandom_range(6)),
          base + sp + int'($urandom_range(3)), base, int'($urandom_range(3)), "R5 R6 R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule